// File: doc/BRIEF.md
# Rotating Word Seven-Segment Display

This block drives a row of six seven-segment digits with a fixed four-letter word, "dE10", padded by two blank positions. A 3-bit rotation select picks one of six positions of the word on the row. Each step of the select moves the whole pattern one digit to the left, and a character that leaves the leftmost digit comes back in at the rightmost. The block is purely combinational. It has no clock and no stored state, so the segment outputs follow the select directly.

Each digit position has its own 3-bit-wide, six-input multiplexer. The data inputs of that multiplexer are constant character codes, wired in the rotated order that suits that position. The multiplexer output feeds a character-to-segment decoder. The character set has five symbols: the four glyphs of the word and a blank. The two select values that name no rotation position blank the whole row.

Top module: `rot_word_display`

## Requirements
- R1: Segment buses are active-low. Bit 0 is segment a and bit 6 is segment g. The glyphs are: d lights b,c,d,e,g (7'b0100001); E lights a,d,e,f,g (7'b0000110); 1 lights b,c (7'b1111001); 0 lights a-f (7'b1000000); blank lights nothing (7'h7F). No other segment value ever appears.
- R2: With rot_sel = 0, the digits from seg_l0 (leftmost) to seg_l5 (rightmost) show blank, blank, d, E, 1, 0.
- R3: For rot_sel = s with s from 0 to 4, the digit at position i under s+1 equals the digit at position (i+1) mod 6 under s. This is a left rotation with wraparound.
- R4: rot_sel = 1 shows blank, d, E, 1, 0, blank. rot_sel = 2 shows d, E, 1, 0, blank, blank.
- R5: rot_sel = 3 shows E, 1, 0, blank, blank, d. rot_sel = 4 shows 1, 0, blank, blank, d, E. rot_sel = 5 shows 0, blank, blank, d, E, 1.
- R6: rot_sel = 6 and rot_sel = 7 blank all six digits.
- R7: For rot_sel from 0 to 5, exactly two digits are blank, and each of d, E, 1 and 0 appears exactly once.
- R8: The outputs depend only on the present rot_sel. The same select gives the same pattern whatever sequence of selects came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rot_sel | input | 3 | Rotation position, 0 to 5; values 6 and 7 blank the row |
| seg_l0 | output | 7 | Active-low segments of the leftmost digit |
| seg_l1 | output | 7 | Active-low segments of digit 1 |
| seg_l2 | output | 7 | Active-low segments of digit 2 |
| seg_l3 | output | 7 | Active-low segments of digit 3 |
| seg_l4 | output | 7 | Active-low segments of digit 4 |
| seg_l5 | output | 7 | Active-low segments of the rightmost digit |

## Verification
The case hardest to bring about from the ports is a pattern that depends on history instead of on the present select. One example is a wrap error that shows up only after a jump from an out-of-range value back to a low position. The stimulus first sweeps the selects in order, then walks them downward, then jumps among them in a scrambled order that includes 6 and 7 between legal positions. The behavioural model recomputes every digit on every clock. Consecutive sweep patterns are also compared with each other, so that the one-step left rotation is checked on its own terms.

// File: rtl/rot_word_pkg.sv
package rot_word_pkg;

  localparam int NUM_DIGITS = 6;
  localparam int CODE_W     = 3;
  localparam int SEG_W      = 7;
  localparam int SEL_W      = 3;

  typedef enum logic [CODE_W-1:0] {
    CH_D     = 3'd0,
    CH_E     = 3'd1,
    CH_ONE   = 3'd2,
    CH_ZERO  = 3'd3,
    CH_BLANK = 3'd4
  } char_e;

  // Character shown at a digit position when the rotation select is zero.
  function automatic logic [CODE_W-1:0] home_char(input int pos);
    case (pos)
      2:       home_char = CH_D;
      3:       home_char = CH_E;
      4:       home_char = CH_ONE;
      5:       home_char = CH_ZERO;
      default: home_char = CH_BLANK;
    endcase
  endfunction

  // Home-pattern index that lands on position pos after step left shifts.
  function automatic int rot_index(input int pos, input int step, input int n);
    rot_index = (pos + step) % n;
  endfunction

  // Active-low glyph, bit 0 = segment a ... bit 6 = segment g.
  function automatic logic [SEG_W-1:0] char_glyph(input logic [CODE_W-1:0] code);
    case (code)
      CH_D:    char_glyph = 7'b0100001;
      CH_E:    char_glyph = 7'b0000110;
      CH_ONE:  char_glyph = 7'b1111001;
      CH_ZERO: char_glyph = 7'b1000000;
      default: char_glyph = 7'b1111111;
    endcase
  endfunction

endpackage

// File: rtl/rot_char_mux.sv
module rot_char_mux
  import rot_word_pkg::*;
#(
  parameter int DIGIT_POS = 0,
  parameter int NUM_POS   = NUM_DIGITS,
  parameter int SW        = SEL_W,
  parameter int CW        = CODE_W
) (
  input  logic [SW-1:0] sel,
  output logic [CW-1:0] code,
  output logic          sel_in_range
);

  logic [CW-1:0] data_in [NUM_POS];

  // Constant data inputs, wired in the rotated order for this position.
  for (genvar k = 0; k < NUM_POS; k++) begin : g_const
    assign data_in[k] = CW'(home_char(rot_index(DIGIT_POS, k, NUM_POS)));
  end

  always_comb begin
    code         = CW'(CH_BLANK);
    sel_in_range = 1'b0;
    for (int k = 0; k < NUM_POS; k++) begin
      if (sel == SW'(k)) begin
        code         = data_in[k];
        sel_in_range = 1'b1;
      end
    end
  end

endmodule

// File: rtl/char_seg_decoder.sv
module char_seg_decoder
  import rot_word_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int GW = SEG_W
) (
  input  logic [CW-1:0] code,
  output logic [GW-1:0] seg_n,
  output logic          code_legal
);

  always_comb begin
    seg_n      = GW'(char_glyph(code));
    code_legal = (code <= CW'(CH_BLANK));
  end

endmodule

// File: rtl/rot_word_display.sv
module rot_word_display
  import rot_word_pkg::*;
(
  input  logic [2:0] rot_sel,
  output logic [6:0] seg_l0,
  output logic [6:0] seg_l1,
  output logic [6:0] seg_l2,
  output logic [6:0] seg_l3,
  output logic [6:0] seg_l4,
  output logic [6:0] seg_l5
);

  logic [NUM_DIGITS-1:0][SEG_W-1:0]  seg_bus;
  logic [NUM_DIGITS-1:0][CODE_W-1:0] code_bus;
  logic [NUM_DIGITS-1:0]             sel_hit;
  logic [NUM_DIGITS-1:0]             code_ok;
  logic                              sel_ok;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    rot_char_mux #(
      .DIGIT_POS(d), .NUM_POS(NUM_DIGITS), .SW(SEL_W), .CW(CODE_W)
    ) u_mux (
      .sel          (rot_sel),
      .code         (code_bus[d]),
      .sel_in_range (sel_hit[d])
    );
    char_seg_decoder #(.CW(CODE_W), .GW(SEG_W)) u_dec (
      .code       (code_bus[d]),
      .seg_n      (seg_bus[d]),
      .code_legal (code_ok[d])
    );
  end

  assign sel_ok = &sel_hit;

  assign seg_l0 = seg_bus[0];
  assign seg_l1 = seg_bus[1];
  assign seg_l2 = seg_bus[2];
  assign seg_l3 = seg_bus[3];
  assign seg_l4 = seg_bus[4];
  assign seg_l5 = seg_bus[5];

endmodule

// File: rtl/rot_word_display_chk.sv
module rot_word_display_chk
  import rot_word_pkg::*;
(
  input logic [2:0]                        rot_sel,
  input logic [NUM_DIGITS-1:0][SEG_W-1:0]  seg_bus,
  input logic [NUM_DIGITS-1:0][CODE_W-1:0] code_bus,
  input logic [NUM_DIGITS-1:0]             code_ok,
  input logic                              sel_ok
);

  int blanks;
  logic glyphs_legal;

  always_comb begin
    blanks       = 0;
    glyphs_legal = 1'b1;
    for (int d = 0; d < NUM_DIGITS; d++) begin
      if (seg_bus[d] == 7'h7F) blanks++;
      if (!(seg_bus[d] == 7'b0100001 || seg_bus[d] == 7'b0000110 ||
            seg_bus[d] == 7'b1111001 || seg_bus[d] == 7'b1000000 ||
            seg_bus[d] == 7'h7F))
        glyphs_legal = 1'b0;
    end
  end

  always_comb begin
    a_r1_legal_glyph: assert (glyphs_legal)
      else $error("R1 illegal segment value");
    a_r1_codes_in_set: assert (&code_ok)
      else $error("R1 multiplexer produced an unused code");
    a_r6_blank_row: assert (rot_sel < 3'd6 || blanks == NUM_DIGITS)
      else $error("R6 row not blank for out-of-range select");
    a_r7_two_blanks: assert (rot_sel >= 3'd6 || blanks == 2)
      else $error("R7 blank count wrong");
    a_r6_range_flag: assert (sel_ok == (rot_sel < 3'd6))
      else $error("R6 select range flag disagrees with select");
  end

endmodule

bind rot_word_display rot_word_display_chk u_chk (
  .rot_sel  (rot_sel),
  .seg_bus  (seg_bus),
  .code_bus (code_bus),
  .code_ok  (code_ok),
  .sel_ok   (sel_ok)
);

// File: tb/rot_word_display_tb.sv
module rot_word_display_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rot_sel = 3'd0;
  logic [6:0] s0, s1, s2, s3, s4, s5;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #4 clk = ~clk; // 125 MHz

  rot_word_display u_dut (
    .rot_sel(rot_sel), .seg_l0(s0), .seg_l1(s1), .seg_l2(s2),
    .seg_l3(s3), .seg_l4(s4), .seg_l5(s5)
  );

  // Glyph built from the list of lit segment letters (active-low).
  function automatic logic [6:0] glyph_of(input byte ch);
    string lit;
    logic [6:0] g;
    case (ch)
      "d":     lit = "bcdeg";
      "E":     lit = "adefg";
      "1":     lit = "bc";
      "0":     lit = "abcdef";
      default: lit = "";
    endcase
    g = 7'h7F;
    for (int i = 0; i < lit.len(); i++) g[lit[i] - "a"] = 1'b0;
    return g;
  endfunction

  function automatic logic [6:0] model_digit(input int sel, input int pos);
    string word;
    word = "  dE10";
    if (sel > 5) return glyph_of(" ");
    return glyph_of(word[(pos + sel) % 6]);
  endfunction

  function automatic logic [6:0] dut_digit(input int pos);
    case (pos)
      0: return s0; 1: return s1; 2: return s2;
      3: return s3; 4: return s4; default: return s5;
    endcase
  endfunction

  function automatic string tag_of(input int sel);
    case (sel)
      0:       return "R2";
      1, 2:    return "R4";
      3, 4, 5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int p = 0; p < 6; p++) begin
        n_checks++;
        if (dut_digit(p) !== model_digit(int'(rot_sel), p)) begin
          n_fail++;
          $display("FAIL %s/R8 sel=%0d digit %0d actual=%b expected=%b",
                   tag_of(int'(rot_sel)), rot_sel, p, dut_digit(p),
                   model_digit(int'(rot_sel), p));
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic apply(input int sel);
    @(posedge clk);
    rot_sel <= 3'(sel);
    @(negedge clk);
  endtask

  logic [6:0] prev [6];
  logic [6:0] cur  [6];
  int order [12] = '{7, 3, 0, 6, 5, 1, 4, 2, 7, 0, 3, 5};

  initial begin
    // Reset state: select 0 gives the home pattern (R2).
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    n_checks++;
    if (s0 !== 7'h7F || s2 !== 7'b0100001 || s5 !== 7'b1000000) begin
      n_fail++;
      $display("FAIL R2 reset pattern actual=%b_%b expected=%b_%b",
               s0, s2, 7'h7F, 7'b0100001);
    end

    // Upward sweep with R1, R3 and R7 checks.
    for (int s = 0; s < 8; s++) begin
      apply(s);
      for (int p = 0; p < 6; p++) cur[p] = dut_digit(p);
      if (s < 6) begin
        int nb, nd, ne, n1, n0;
        nb = 0; nd = 0; ne = 0; n1 = 0; n0 = 0;
        for (int p = 0; p < 6; p++) begin
          if (cur[p] == glyph_of(" ")) nb++;
          else if (cur[p] == glyph_of("d")) nd++;
          else if (cur[p] == glyph_of("E")) ne++;
          else if (cur[p] == glyph_of("1")) n1++;
          else if (cur[p] == glyph_of("0")) n0++;
        end
        n_checks++;
        if (nb != 2 || nd != 1 || ne != 1 || n1 != 1 || n0 != 1) begin
          n_fail++;
          $display("FAIL R7/R1 sel=%0d counts actual=%0d%0d%0d%0d%0d expected=21111",
                   s, nb, nd, ne, n1, n0);
        end
      end
      if (s >= 1 && s <= 5) begin
        for (int p = 0; p < 6; p++) begin
          n_checks++;
          if (cur[p] !== prev[(p + 1) % 6]) begin
            n_fail++;
            $display("FAIL R3 sel=%0d digit %0d actual=%b expected=%b",
                     s, p, cur[p], prev[(p + 1) % 6]);
          end
        end
      end
      for (int p = 0; p < 6; p++) prev[p] = cur[p];
    end

    // Downward walk and scrambled jumps (R8, R6), checked per clock.
    for (int s = 7; s >= 0; s--) apply(s);
    foreach (order[i]) begin
      apply(order[i]);
      apply(order[i]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule